// File: doc/BRIEF.md
# Packed Decimal Adder/Subtractor

This unit adds or subtracts two packed BCD numbers of `DIGITS` decimal digits (four by default). It does so in a single pass of combinational logic. Each digit position has a 4-bit binary adder followed by a decimal fix-up. The positions are chained so that the decimal carry of one digit enters the next more significant digit.

In subtract mode the second operand first goes through a digit-wise nines complementer, and the result is added to the first operand. If this pass carries out of the top digit, the carry is fed back into the least significant digit through a second correcting pass, which is the end-around carry. That carry may ripple across digits that were already corrected. If there is no final carry, the difference is negative. It is then delivered unchanged, in nines complement form, with a flag raised.

The data path sits between a valid/ready producer and consumer and holds no storage. A result is offered in the same cycle its operands are offered. The consumer applies back-pressure by holding ready low. The producer must then keep its operands and mode stable until the transfer completes, and it completes on any clock edge where valid and ready are both high.

Top module: `bcd_addsub`

## Requirements
- R1: With mode = 0, result is the decimal sum of a and b modulo 10^DIGITS, and carry_out is 1 exactly when the sum is 10^DIGITS or more.
- R2: Every result digit, at bit positions [4k+3:4k] with digit 0 least significant, is a value from 0 to 9. A digit whose raw binary sum exceeds 9 or carries out of its top bit is corrected by adding 6.
- R3: A decimal carry from one digit enters the next digit up and can ripple across several digits (0999 + 0001 = 1000).
- R4: In subtract mode each digit d of b is replaced by 9 - d before the addition.
- R5: With mode = 1 and a > b, result is a - b and negative is 0. The end-around carry is added at the least significant digit and may ripple through corrected digits (1000 - 0001 = 0999).
- R6: With mode = 1 and a < b, negative is 1 and result is the nines complement of b - a, namely (10^DIGITS - 1) - (b - a).
- R7: With mode = 1 and a = b, result has all digits 9 and negative is 1.
- R8: carry_out is 0 whenever mode = 1, and negative is 0 whenever mode = 0.
- R9: out_valid follows in_valid and in_ready follows out_ready in the same cycle. The result depends only on the present a, b and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 1 | 0 = add, 1 = subtract |
| a | input | 4*DIGITS | First operand, packed BCD |
| b | input | 4*DIGITS | Second operand, packed BCD |
| in_valid | input | 1 | Operands offered |
| in_ready | output | 1 | Unit can take operands |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes result |
| result | output | 4*DIGITS | BCD sum or difference |
| carry_out | output | 1 | Decimal carry of an addition |
| negative | output | 1 | Subtraction result is negative |

## Verification
In one operation, the per-digit decimal correction and the end-around carry can act together. The end-around carry then ripples through digits that the first pass has just corrected. Subtractions are chosen to provoke this, for example 1000 - 0001 and 5000 - 0999, along with chains of 9s. They are judged against an integer model that converts both operands to integers and computes the expected difference, or the expected nines complement form for a negative result.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam logic [3:0] NINE    = 4'd9;
  localparam logic [3:0] FIX_SIX = 4'd6;
  localparam logic [3:0] COMP_K  = 4'b1010;

  function automatic logic digit_ok(input logic [3:0] d);
    return d <= NINE;
  endfunction
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell
  import bcd_pkg::*;
(
  input  logic [3:0] x,
  input  logic [3:0] y,
  input  logic       ci,
  output logic [3:0] s,
  output logic       co
);
  logic [4:0] raw;
  logic       fix;

  always_comb begin
    raw = {1'b0, x} + {1'b0, y} + {4'b0000, ci};
    fix = raw[4] | (raw[3:0] > NINE);
    s   = fix ? (raw[3:0] + FIX_SIX) : raw[3:0];
    co  = fix;
  end

  always_comb begin
    if (digit_ok(x) && digit_ok(y)) begin
      // R2
      digit_range_chk: assert (digit_ok(s));
    end
  end
endmodule

// File: rtl/bcd_nines.sv
module bcd_nines
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] d,
  input  logic         en,
  output logic [W-1:0] q
);
  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    logic [3:0] din, dout;
    assign din = d[k*DIGIT_W +: DIGIT_W];
    assign dout = en ? ((~din) + COMP_K) : din;
    assign q[k*DIGIT_W +: DIGIT_W] = dout;

    always_comb begin
      if (en && digit_ok(din)) begin
        // R4
        nines_sum_chk: assert (({1'b0, din} + {1'b0, dout}) == 5'd9);
      end
    end
  end
endmodule

// File: rtl/bcd_ripple.sv
module bcd_ripple
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [DIGITS:0] cy;
  assign cy[0] = ci;

  for (genvar k = 0; k < DIGITS; k++) begin : g_cell
    bcd_digit_cell u_cell (
      .x  (x[k*DIGIT_W +: DIGIT_W]),
      .y  (y[k*DIGIT_W +: DIGIT_W]),
      .ci (cy[k]),
      .s  (s[k*DIGIT_W +: DIGIT_W]),
      .co (cy[k+1])
    );
  end

  assign co = cy[DIGITS];
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = DIGITS * DIGIT_W
) (
  input  logic         mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         in_valid,
  output logic         in_ready,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         negative
);
  logic [W-1:0] b_eff;
  logic [W-1:0] pass1;
  logic [W-1:0] pass2;
  logic         c1;
  logic         c2;
  logic         eac;

  bcd_nines #(.DIGITS(DIGITS)) u_comp (
    .d  (b),
    .en (mode),
    .q  (b_eff)
  );

  bcd_ripple #(.DIGITS(DIGITS)) u_pass1 (
    .x  (a),
    .y  (b_eff),
    .ci (1'b0),
    .s  (pass1),
    .co (c1)
  );

  assign eac = mode & c1;

  bcd_ripple #(.DIGITS(DIGITS)) u_pass2 (
    .x  (pass1),
    .y  ({W{1'b0}}),
    .ci (eac),
    .s  (pass2),
    .co (c2)
  );

  assign result    = pass2;
  assign carry_out = ~mode & c1;
  assign negative  = mode & ~c1;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

  logic ops_ok;
  always_comb begin
    ops_ok = 1'b1;
    for (int k = 0; k < int'(DIGITS); k++) begin
      if (!digit_ok(a[k*DIGIT_W +: DIGIT_W]) || !digit_ok(b[k*DIGIT_W +: DIGIT_W]))
        ops_ok = 1'b0;
    end
  end

  always_comb begin
    if (ops_ok) begin
      // R5
      eac_no_ovf_chk: assert (!c2);
      // R7
      zero_diff_chk: assert (!(mode && (a == b)) || negative);
      // R8
      flag_excl_chk: assert (!(carry_out && negative));
    end
  end
endmodule

// File: tb/bcd_addsub_tb_top.sv
module bcd_addsub_tb_top;
  localparam int DIGITS = 4;
  localparam int W = DIGITS * 4;
  localparam int MAXV = 9999;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         mode = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         in_valid = 1'b0, out_ready = 1'b0;
  logic         in_ready, out_valid, carry_out, negative;
  logic [W-1:0] result;

  int n_tests = 0;
  int n_fail = 0;

  bcd_addsub #(.DIGITS(DIGITS)) dut_i (
    .mode(mode), .a(a), .b(b), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .result(result),
    .carry_out(carry_out), .negative(negative)
  );

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    for (int k = 0; k < DIGITS; k++) begin
      r[k*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic m, input int ia, input int ib);
    @(negedge clk);
    mode = m; a = to_bcd(ia); b = to_bcd(ib); in_valid = 1'b1; out_ready = 1'b1;
    #1;
  endtask

  task automatic do_add(input string req, input int ia, input int ib);
    int s;
    apply(1'b0, ia, ib);
    s = ia + ib;
    check(req, result, to_bcd(s % (MAXV + 1)));
    check({req, " carry"}, carry_out, (s > MAXV) ? 1 : 0);
    check("R8 add neg", negative, 0);
  endtask

  task automatic do_sub(input string req, input int ia, input int ib);
    apply(1'b1, ia, ib);
    if (ia > ib) begin
      check(req, result, to_bcd(ia - ib));
      check({req, " neg"}, negative, 0);
    end else begin
      check(req, result, to_bcd(MAXV - (ib - ia)));
      check({req, " neg"}, negative, 1);
    end
    check("R8 sub carry", carry_out, 0);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    check("R9 idle out_valid", out_valid, 0);
    check("R9 idle in_ready", in_ready, 0);
    check("R1 zero sum", result, 0);
  endtask

  task automatic t_add_directed;
    do_add("R1", 1234, 4321);
    do_add("R2", 5, 8);
    do_add("R2", 9, 9);
    do_add("R3", 999, 1);
    do_add("R3", 9999, 1);
    do_add("R1", 9999, 9999);
  endtask

  task automatic t_add_random;
    for (int i = 0; i < 200; i++)
      do_add("R1 rnd", int'($urandom_range(0, MAXV)), int'($urandom_range(0, MAXV)));
  endtask

  task automatic t_sub_directed;
    do_sub("R5", 1000, 1);
    do_sub("R5", 5000, 999);
    do_sub("R5", 9999, 0);
    do_sub("R4", 8765, 1234);
    do_sub("R6", 1, 1000);
    do_sub("R6", 0, 9999);
    do_sub("R6", 250, 1250);
  endtask

  task automatic t_sub_equal;
    apply(1'b1, 4242, 4242);
    check("R7 equal", result, to_bcd(MAXV));
    check("R7 equal neg", negative, 1);
    apply(1'b1, 0, 0);
    check("R7 zero", result, to_bcd(MAXV));
  endtask

  task automatic t_sub_random;
    for (int i = 0; i < 200; i++)
      do_sub("R5R6 rnd", int'($urandom_range(0, MAXV)), int'($urandom_range(0, MAXV)));
  endtask

  task automatic t_handshake;
    apply(1'b0, 12, 34);
    out_ready = 1'b0; #1;
    check("R9 stall in_ready", in_ready, 0);
    check("R9 stall out_valid", out_valid, 1);
    check("R9 stall result", result, to_bcd(46));
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1; #1;
    check("R9 drop out_valid", out_valid, 0);
    check("R9 ready in_ready", in_ready, 1);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_add_directed();
    t_add_random();
    t_sub_directed();
    t_sub_equal();
    t_sub_random();
    t_handshake();
    summary();
    $finish;
  end
endmodule